// File: doc/BRIEF.md
# Transfer Descriptor Slot Scheduler

The block picks which of a bank of transfer descriptor slots runs next. Each slot is a candidate only when the executor reports it as valid and software has not masked it in the skip register. The search is round-robin and moves upward from the slot that ran last. Software can shorten the search window with a wrap-point bitmap, so a bank that uses only a few low slots does not search the empty upper ones.

The executor holds a registered grant (a valid flag and a slot index) until it pulses the advance input. With that pulse it may offer a follow-on slot index taken from the finished descriptor. The scheduler jumps to that slot when it is a candidate. Otherwise it falls back to the round-robin order. Completions arrive as a pulse with a slot index and are gathered in a completion bitmap, which is cleared by reading it through a small 32-bit register bus.

The register map uses word addresses. Address 0 holds the skip mask (read/write), address 1 holds the wrap points (read/write), address 2 holds the completion bitmap (read-only, cleared on read), and address 3 reads as zero. In every map, bit n belongs to slot n.

Top module: `slot_scheduler`

## Requirements
- R1: After reset the skip mask reads FFFF_FFFFh and the wrap-point map and the completion bitmap read 0000_0000h. The grant-valid output is low, and it stays low while every slot is masked, even when all slots are valid.
- R2: A slot is a candidate only when its valid input is 1 and its skip bit is 0. A masked slot is never granted.
- R3: On an advance pulse with no follow-on slot, the grant moves to the next higher candidate above the current slot. Without an advance pulse, a granted slot that is still a candidate stays granted.
- R4: When the current slot is at or below a set wrap-point bit, the search stops at that bit. If no candidate lies between the current slot and that bit, the search restarts from slot 0. Candidates above the wrap point are then not granted.
- R5: When several wrap-point bits are set, the lowest set bit at or above the current slot is the active wrap point. When the search restarts from slot 0, the lowest set bit overall limits it.
- R6: With the wrap-point map at zero, the search covers all 32 slots and wraps from slot 31 to slot 0.
- R7: On an advance pulse whose follow-on valid input is 1, the grant goes to the follow-on slot when that slot is a candidate. When it is masked, the follow-on index is ignored and the round-robin order applies.
- R8: When no slot is a candidate, grant-valid goes low and the scan position holds. The grant-slot output keeps its last value, and the next search starts above that held position.
- R9: A completion pulse for slot n sets bit n of the completion bitmap, and the bit is visible to the next read.
- R10: A read at address 2 returns the completion bitmap and clears every bit it returned. A completion that arrives in the same cycle as the read is not returned by that read but appears in the next one.
- R11: Writes to address 2 have no effect. The values written to addresses 0 and 1 read back unchanged.
- R12: When the granted slot stops being a candidate, it is dropped at the next clock edge and a new slot is chosen, starting from the slot after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (clears the completion bitmap when the address is 2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| slot_valid | input | 32 | Per-slot valid bits from the executor |
| done_pulse | input | 1 | A slot has completed |
| done_slot | input | 5 | Index of the completed slot |
| adv | input | 1 | Executor requests the next slot |
| nxt_valid | input | 1 | A follow-on slot index accompanies adv |
| nxt_slot | input | 5 | Follow-on slot index |
| grant_valid | output | 1 | A slot is granted |
| grant_slot | output | 5 | Granted slot index (holds while grant_valid is low) |

## Verification
The bench builds the block with its default of 32 slots. At that size slot 31 is both the top of the full window and the last follow-on target before the wrap, and the register bus is exactly one bitmap wide, so every mask value the bench writes reaches the scan unchanged. Using the full width also allows two wrap points at slots 5 and 10 to be set at the same time, with the follow-on jump used to move the scan above the first one.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

    localparam int REG_ADDR_W = 2;

    typedef enum logic [REG_ADDR_W-1:0] {
        REG_SKIP = 2'd0,
        REG_WRAP = 2'd1,
        REG_DONE = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/slot_find_first.sv
// Lowest set bit of mask whose index lies in [lo, hi]; empty range when lo > hi.
module slot_find_first #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  mask,
    input  logic [IW:0]   lo,
    input  logic [IW:0]   hi,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && ((IW+1)'(i) >= lo) && ((IW+1)'(i) <= hi)) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/slot_sched_regs.sv
module slot_sched_regs
    import slot_sched_pkg::*;
#(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [N-1:0]          bus_wdata,
    output logic [N-1:0]          bus_rdata,
    input  logic                  done_pulse,
    input  logic [IW-1:0]         done_slot,
    output logic [N-1:0]          skip_map,
    output logic [N-1:0]          wrap_map
);

    typedef struct packed {
        logic [N-1:0] skip;
        logic [N-1:0] wrap;
        logic [N-1:0] done;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     rd_done;
    logic [N-1:0] set_mask;

    assign sel     = reg_sel_e'(bus_addr);
    assign rd_done = bus_rd && (sel == REG_DONE);

    always_comb begin
        r_d      = r_q;
        set_mask = done_pulse ? (N'(1) << done_slot) : '0;
        if (bus_wr) begin
            case (sel)
                REG_SKIP: r_d.skip = bus_wdata;
                REG_WRAP: r_d.wrap = bus_wdata;
                default:  ;
            endcase
        end
        // read clears what it returned; a same-cycle completion survives
        r_d.done = (rd_done ? '0 : r_q.done) | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.skip <= '1;
            r_q.wrap <= '0;
            r_q.done <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (sel)
            REG_SKIP: bus_rdata = r_q.skip;
            REG_WRAP: bus_rdata = r_q.wrap;
            REG_DONE: bus_rdata = r_q.done;
            default:  bus_rdata = '0;
        endcase
    end

    assign skip_map = r_q.skip;
    assign wrap_map = r_q.wrap;

    assert_done_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> r_q.done[$past(done_slot)]);

    assert_done_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !done_pulse) |=> (r_q.done == '0));

    assert_done_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_DONE && !rd_done && !done_pulse) |=> $stable(r_q.done));

endmodule

// File: rtl/slot_sched_scan.sv
module slot_sched_scan #(
    parameter int N  = 32,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  elig,
    input  logic [N-1:0]  wrap_map,
    input  logic          adv,
    input  logic          nxt_valid,
    input  logic [IW-1:0] nxt_slot,
    output logic          grant_valid,
    output logic [IW-1:0] grant_slot
);

    localparam logic [IW-1:0] TOP = IW'(N - 1);

    typedef struct packed {
        logic          gv;
        logic [IW-1:0] cur;
    } scan_t;

    scan_t s_d, s_q;

    logic          up_found, low_found, seg1_found, seg2_found;
    logic [IW-1:0] up_idx, low_idx, seg1_idx, seg2_idx;
    logic [IW-1:0] upper, lower;
    logic [IW:0]   seg1_lo;

    // active wrap point at or above the current position
    slot_find_first #(.N(N), .IW(IW)) i_up (
        .mask (wrap_map),
        .lo   ((IW+1)'(s_q.cur)),
        .hi   ((IW+1)'(TOP)),
        .found(up_found),
        .idx  (up_idx)
    );

    // wrap point that bounds the restart from slot 0
    slot_find_first #(.N(N), .IW(IW)) i_low (
        .mask (wrap_map),
        .lo   ('0),
        .hi   ((IW+1)'(TOP)),
        .found(low_found),
        .idx  (low_idx)
    );

    assign upper   = up_found  ? up_idx  : TOP;
    assign lower   = low_found ? low_idx : TOP;
    assign seg1_lo = (IW+1)'(s_q.cur) + (IW+1)'(1);

    slot_find_first #(.N(N), .IW(IW)) i_seg1 (
        .mask (elig),
        .lo   (seg1_lo),
        .hi   ((IW+1)'(upper)),
        .found(seg1_found),
        .idx  (seg1_idx)
    );

    slot_find_first #(.N(N), .IW(IW)) i_seg2 (
        .mask (elig),
        .lo   ('0),
        .hi   ((IW+1)'(lower)),
        .found(seg2_found),
        .idx  (seg2_idx)
    );

    logic need_pick, jump_ok;

    always_comb begin
        s_d       = s_q;
        need_pick = adv || !s_q.gv || !elig[s_q.cur];
        jump_ok   = adv && nxt_valid && elig[nxt_slot];
        if (need_pick) begin
            if (jump_ok) begin
                s_d.gv  = 1'b1;
                s_d.cur = nxt_slot;
            end else if (seg1_found) begin
                s_d.gv  = 1'b1;
                s_d.cur = seg1_idx;
            end else if (seg2_found) begin
                s_d.gv  = 1'b1;
                s_d.cur = seg2_idx;
            end else begin
                s_d.gv  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.gv  <= 1'b0;
            s_q.cur <= TOP;
        end else begin
            s_q <= s_d;
        end
    end

    assign grant_valid = s_q.gv;
    assign grant_slot  = s_q.cur;

    // candidate set seen at the edge that produced the current grant
    logic [N-1:0] elig_prev;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elig_prev <= '0;
        else        elig_prev <= elig;
    end

    assert_grant_eligible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.gv |-> elig_prev[s_q.cur]);

    assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.gv |-> $stable(s_q.cur));

    assert_keep_without_adv_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gv && !adv && elig[s_q.cur]) |=> (s_q.gv && $stable(s_q.cur)));

    assert_drop_ineligible_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.gv && !elig[s_q.cur]) |=> (!s_q.gv || $changed(s_q.cur)));

endmodule

// File: rtl/slot_scheduler.sv
module slot_scheduler
    import slot_sched_pkg::*;
#(
    parameter int NUM_SLOTS = 32,
    localparam int IW = $clog2(NUM_SLOTS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [NUM_SLOTS-1:0]  bus_wdata,
    output logic [NUM_SLOTS-1:0]  bus_rdata,
    input  logic [NUM_SLOTS-1:0]  slot_valid,
    input  logic                  done_pulse,
    input  logic [IW-1:0]         done_slot,
    input  logic                  adv,
    input  logic                  nxt_valid,
    input  logic [IW-1:0]         nxt_slot,
    output logic                  grant_valid,
    output logic [IW-1:0]         grant_slot
);

    logic [NUM_SLOTS-1:0] skip_map, wrap_map, elig;

    slot_sched_regs #(.N(NUM_SLOTS), .IW(IW)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .done_pulse(done_pulse),
        .done_slot (done_slot),
        .skip_map  (skip_map),
        .wrap_map  (wrap_map)
    );

    assign elig = slot_valid & ~skip_map;

    slot_sched_scan #(.N(NUM_SLOTS), .IW(IW)) i_scan (
        .clk        (clk),
        .rst_n      (rst_n),
        .elig       (elig),
        .wrap_map   (wrap_map),
        .adv        (adv),
        .nxt_valid  (nxt_valid),
        .nxt_slot   (nxt_slot),
        .grant_valid(grant_valid),
        .grant_slot (grant_slot)
    );

endmodule

// File: tb/test_slot_scheduler.sv
`timescale 1ns/1ps
module test_slot_scheduler;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic [31:0] slot_valid = '1;
    logic        done_pulse = 1'b0;
    logic [4:0]  done_slot = '0;
    logic        adv = 1'b0, nxt_valid = 1'b0;
    logic [4:0]  nxt_slot = '0;
    logic        grant_valid;
    logic [4:0]  grant_slot;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    slot_scheduler i_slot_scheduler (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slot_valid(slot_valid),
        .done_pulse(done_pulse), .done_slot(done_slot), .adv(adv), .nxt_valid(nxt_valid),
        .nxt_slot(nxt_slot), .grant_valid(grant_valid), .grant_slot(grant_slot)
    );

    // scoreboard: driver side pushes, monitor side pops and compares
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic push_exp(input logic [31:0] v, input string tag);
        exp_q.push_back(v);
        tag_q.push_back(tag);
    endtask

    task automatic monitor_pop(input logic [31:0] actual);
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (actual !== e) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", t, actual, e);
        end
    endtask

    function automatic logic [31:0] g(input logic v, input int s);
        return {26'd0, v, 5'(s)};
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_grant(input logic v, input int s, input string tag);
        push_exp(g(v, s), tag);
        monitor_pop({26'd0, grant_valid, grant_slot});
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic check_read(input logic [1:0] a, input logic [31:0] e, input string tag);
        logic [31:0] got;
        bus_addr = a; bus_rd = 1'b1;
        #1 got = bus_rdata;
        push_exp(e, tag);
        tick();
        bus_rd = 1'b0;
        monitor_pop(got);
    endtask

    task automatic step(input logic nv, input int ns);
        adv = 1'b1; nxt_valid = nv; nxt_slot = 5'(ns);
        tick();
        adv = 1'b0; nxt_valid = 1'b0;
    endtask

    task automatic complete(input int s);
        done_pulse = 1'b1; done_slot = 5'(s);
        tick();
        done_pulse = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_grant(1'b0, 31, "R1 grant idle after reset");
        tick();
        check_grant(1'b0, 31, "R1 all slots masked though valid");
        check_read(2'd0, 32'hFFFF_FFFF, "R1 skip reset");
        check_read(2'd1, 32'h0, "R1 wrap reset");
        check_read(2'd2, 32'h0, "R1 done reset");

        // unmask all but slot 2
        bus_write(2'd0, 32'h0000_0004);
        tick();
        check_grant(1'b1, 0, "R3 first pick slot 0");
        step(1'b0, 0);  check_grant(1'b1, 1, "R3 advance to 1");
        step(1'b0, 0);  check_grant(1'b1, 3, "R2 masked slot 2 passed over");
        step(1'b0, 0);  check_grant(1'b1, 4, "R3 advance to 4");
        tick();         check_grant(1'b1, 4, "R3 hold without advance");

        // wrap point at slot 5
        bus_write(2'd1, 32'h0000_0020);
        step(1'b0, 0);  check_grant(1'b1, 5, "R4 reach wrap point");
        step(1'b0, 0);  check_grant(1'b1, 0, "R4 wrap to slot 0");

        // wrap points at 5 and 10
        bus_write(2'd1, 32'h0000_0420);
        step(1'b0, 0);  check_grant(1'b1, 1, "R5 advance to 1");
        step(1'b0, 0);  check_grant(1'b1, 3, "R5 advance to 3");
        step(1'b0, 0);  check_grant(1'b1, 4, "R5 advance to 4");
        step(1'b0, 0);  check_grant(1'b1, 5, "R5 advance to 5");
        step(1'b0, 0);  check_grant(1'b1, 0, "R5 lowest wrap bit used");
        step(1'b1, 7);  check_grant(1'b1, 7, "R7 follow-on jump to 7");
        step(1'b0, 0);  check_grant(1'b1, 8, "R5 advance to 8");
        step(1'b0, 0);  check_grant(1'b1, 9, "R5 advance to 9");
        step(1'b0, 0);  check_grant(1'b1, 10, "R5 second wrap point reached");
        step(1'b0, 0);  check_grant(1'b1, 0, "R5 wrap from 10 to 0");
        step(1'b1, 2);  check_grant(1'b1, 1, "R7 masked follow-on ignored");

        // full window
        bus_write(2'd1, 32'h0);
        step(1'b1, 30); check_grant(1'b1, 30, "R7 follow-on jump to 30");
        step(1'b0, 0);  check_grant(1'b1, 31, "R6 slot 31 reached");
        step(1'b0, 0);  check_grant(1'b1, 0, "R6 wrap from 31 to 0");

        // no candidates
        slot_valid = 32'h0;
        tick();         check_grant(1'b0, 0, "R8 grant drops, slot held");
        tick();         check_grant(1'b0, 0, "R8 position still held");
        slot_valid = 32'h0010_0001;
        tick();         check_grant(1'b1, 20, "R8 search resumes above held slot");

        // mask the granted slot
        bus_write(2'd0, 32'h0010_0004);
        check_grant(1'b1, 20, "R12 grant before mask takes effect");
        tick();         check_grant(1'b1, 0, "R12 masked grant replaced");

        // completion bitmap
        complete(3);
        complete(31);
        check_read(2'd2, 32'h8000_0008, "R9 completions recorded");
        check_read(2'd2, 32'h0, "R10 cleared by read");
        complete(9);
        done_pulse = 1'b1; done_slot = 5'd7;
        check_read(2'd2, 32'h0000_0200, "R10 read with concurrent completion");
        done_pulse = 1'b0;
        check_read(2'd2, 32'h0000_0080, "R10 concurrent completion kept");

        bus_write(2'd2, 32'hFFFF_FFFF);
        check_read(2'd2, 32'h0, "R11 done not writable");
        check_read(2'd0, 32'h0010_0004, "R11 skip readback");
        bus_write(2'd1, 32'h8000_0001);
        check_read(2'd1, 32'h8000_0001, "R11 wrap readback");

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule